// File: doc/BRIEF.md
# Sequencer IRQ Flag Unit

This unit keeps eight single-bit event flags shared by four small program sequencers and by a host processor. Each sequencer can, in any cycle, issue one flag operation (set, clear, or set-then-stall) and one poll that asks whether a flag has a given level. The poll answers in the same cycle through a stall output. A poll for a high level that succeeds also consumes the flag, so a waiting sequencer and a signalling sequencer can hand off an event. A set-then-stall operation raises the flag and holds the issuing sequencer until some other agent has cleared that flag again.

A flag operation or a poll may carry a relative index. For such an index the unit adds the sequencer's own number to the low two index bits, modulo four, and keeps bit 2. The same program therefore reaches a different flag on each sequencer and never crosses between the lower and upper halves. Only the lower half, flags 0 to 3, is exposed to the processor. The processor can read those four flags, clear any of them by writing ones, and drive one interrupt line through a four-bit enable register. Flags 4 to 7 are private to the sequencers.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous active-low reset all eight flags are 0, the enable register is 0, `cpu_irq` is 0 and every `seq_stall` bit is 0.
- R2: A sequencer request with op 2'b00 (set) makes the addressed flag 1 from the cycle after the request edge. Op 2'b11 is reserved and changes no flag.
- R3: A request with op 2'b01 (clear) makes the addressed flag 0 from the cycle after the request edge.
- R4: With the relative bit set, sequencer s addresses flag {idx[2], (idx[1:0] + s) mod 4}. For example, sequencer 3 with idx 2 reaches flag 1, and sequencer 2 with idx 6 reaches flag 4. With the bit clear, idx is used as given.
- R5: When a set and a clear reach the same flag at the same edge, the flag ends at 0. This holds whether the clear comes from a sequencer, from the processor or from a poll completion.
- R6: A poll (`seq_wait_valid`) drives `seq_wait_stall` high in the same cycle while the addressed flag differs from `seq_wait_pol`, and low while it equals it.
- R7: A poll for level 1 that finds its flag high clears that flag at the same edge. A later poll for level 1 then stalls.
- R8: A request with op 2'b10 (set-and-wait) sets the flag and raises `seq_stall` of that sequencer from the next cycle. The stall holds while the flag is high. It drops in the cycle after the first cycle in which the flag is seen low.
- R9: With `cpu_clr_we` high, each 1 in `cpu_clr_mask` clears the matching flag among flags 0 to 3 at the edge. Mask bits that are 0 leave their flags unchanged.
- R10: `cpu_flags` shows flags 0 to 3 only. Flags 4 to 7 never affect `cpu_flags` or `cpu_irq`.
- R11: `cpu_irq` is the OR over flags 0 to 3 of each flag ANDed with its enable bit. The enable register loads `cpu_en_wdata` at an edge where `cpu_en_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_req_valid | input | 4 | Flag operation request, one bit per sequencer |
| seq_req_op | input | 8 | Operation, 2 bits per sequencer: 00 set, 01 clear, 10 set-and-wait, 11 reserved |
| seq_req_idx | input | 12 | Flag index, 3 bits per sequencer |
| seq_req_rel | input | 4 | Relative-index flag for the request |
| seq_stall | output | 4 | Set-and-wait stall, one bit per sequencer |
| seq_wait_valid | input | 4 | Poll active, one bit per sequencer |
| seq_wait_pol | input | 4 | Level the poll waits for |
| seq_wait_idx | input | 12 | Poll flag index, 3 bits per sequencer |
| seq_wait_rel | input | 4 | Relative-index flag for the poll |
| seq_wait_stall | output | 4 | Poll not yet satisfied |
| cpu_clr_we | input | 1 | Processor write-one-to-clear strobe |
| cpu_clr_mask | input | 4 | Flags 0 to 3 to clear |
| cpu_en_we | input | 1 | Enable register write strobe |
| cpu_en_wdata | input | 4 | New enable register value |
| cpu_flags | output | 4 | Flags 0 to 3 |
| cpu_irq | output | 1 | Processor interrupt |

## Verification
The assertions assume that a sequencer issues requests as single-cycle pulses, and that it issues no new request while its `seq_stall` is high. The set-and-wait rise check ties every stall rise to a set-and-wait request at the edge before, so it depends on that rule. The set check looks only at cycles where sequencer 0 acts alone on a visible flag. The clear check looks only at full-mask processor clears with no sequencer activity, so that no competing set hides the outcome. The bench keeps to these rules: it drives each request for exactly one edge, returns every input to idle afterwards, and sends the clear that releases a stalled sequencer from a different sequencer.

// File: rtl/irq_pkg.sv
// Package: shared types for the sequencer IRQ flag unit.
// Assumes: two-bit operation code per sequencer request.
package irq_pkg;
    typedef enum logic [1:0] {
        OP_SET     = 2'b00,
        OP_CLR     = 2'b01,
        OP_SETWAIT = 2'b10,
        OP_NONE    = 2'b11
    } irq_op_e;
endpackage

// File: rtl/irq_idx_resolve.sv
// Module: turns a requested flag index into an absolute one.
// Relative indices add SID to the low bits modulo the half size; the top bit is kept.
// Assumes: IDX_W >= 2.
module irq_idx_resolve #(
    parameter int IDX_W = 3,
    parameter int SID   = 0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             rel,
    output logic [IDX_W-1:0] eff
);
    localparam int LOW_W = IDX_W - 1;
    localparam logic [LOW_W-1:0] SID_L = LOW_W'(SID);

    // Select the absolute or the offset index.
    always_comb begin
        if (rel) eff = {idx[IDX_W-1], idx[LOW_W-1:0] + SID_L};
        else     eff = idx;
    end
endmodule

// File: rtl/irq_setwait_track.sv
// Module: holds one sequencer stalled after a set-and-wait request until its flag is seen low.
// The stall drops one cycle after the first cycle in which the flag reads 0.
// Assumes: no new start while stall is high.
module irq_setwait_track #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IDX_W-1:0]     start_idx,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic                 stall
);
    logic             waiting_q;
    logic [IDX_W-1:0] idx_q;

    // Track the waiting state and the flag it watches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
            idx_q     <= '0;
        end else if (waiting_q) begin
            if (!flags[idx_q]) waiting_q <= 1'b0;
        end else if (start) begin
            waiting_q <= 1'b1;
            idx_q     <= start_idx;
        end
    end

    assign stall = waiting_q;
endmodule

// File: rtl/irq_flag_bank.sv
// Module: flag register with clear-over-set priority, processor clears and interrupt enables.
// Assumes: VIS_FLAGS <= NUM_FLAGS; the visible flags are the lowest ones.
module irq_flag_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int VIS_FLAGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_vec,
    input  logic [NUM_FLAGS-1:0] clr_vec,
    input  logic                 cpu_clr_we,
    input  logic [VIS_FLAGS-1:0] cpu_clr_mask,
    input  logic                 cpu_en_we,
    input  logic [VIS_FLAGS-1:0] cpu_en_wdata,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] flag_q;
    logic [VIS_FLAGS-1:0] en_q;
    logic [NUM_FLAGS-1:0] cpu_clr_full;

    // Widen the processor clear mask to all flags.
    always_comb begin
        cpu_clr_full = '0;
        if (cpu_clr_we) cpu_clr_full[VIS_FLAGS-1:0] = cpu_clr_mask;
    end

    // Update the flags; any clear source beats a set.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q | set_vec) & ~(clr_vec | cpu_clr_full);
    end

    // Hold the interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (cpu_en_we) en_q <= cpu_en_wdata;
    end

    assign flags = flag_q;
    assign irq   = |(flag_q[VIS_FLAGS-1:0] & en_q);
endmodule

// File: rtl/irq_flag_unit.sv
// Module: top of the sequencer IRQ flag unit.
// Resolves indices per sequencer, decodes operations and polls, and feeds the flag bank.
// Assumes: requests are single-cycle pulses; a stalled sequencer issues nothing new.
module irq_flag_unit
    import irq_pkg::*;
#(
    parameter int NUM_SEQ   = 4,
    parameter int NUM_FLAGS = 8,
    parameter int VIS_FLAGS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SEQ-1:0]          seq_req_valid,
    input  logic [2*NUM_SEQ-1:0]        seq_req_op,
    input  logic [3*NUM_SEQ-1:0]        seq_req_idx,
    input  logic [NUM_SEQ-1:0]          seq_req_rel,
    output logic [NUM_SEQ-1:0]          seq_stall,
    input  logic [NUM_SEQ-1:0]          seq_wait_valid,
    input  logic [NUM_SEQ-1:0]          seq_wait_pol,
    input  logic [3*NUM_SEQ-1:0]        seq_wait_idx,
    input  logic [NUM_SEQ-1:0]          seq_wait_rel,
    output logic [NUM_SEQ-1:0]          seq_wait_stall,
    input  logic                        cpu_clr_we,
    input  logic [VIS_FLAGS-1:0]        cpu_clr_mask,
    input  logic                        cpu_en_we,
    input  logic [VIS_FLAGS-1:0]        cpu_en_wdata,
    output logic [VIS_FLAGS-1:0]        cpu_flags,
    output logic                        cpu_irq
);
    localparam int IDX_W = $clog2(NUM_FLAGS);

    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] set_per [NUM_SEQ];
    logic [NUM_FLAGS-1:0] clr_per [NUM_SEQ];
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;

    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
        logic [IDX_W-1:0] req_eff;
        logic [IDX_W-1:0] wait_eff;
        irq_op_e          op;
        logic             start_sw;
        logic             wait_done;

        irq_idx_resolve #(.IDX_W(IDX_W), .SID(s)) u_req_idx (
            .idx (seq_req_idx[3*s +: IDX_W]),
            .rel (seq_req_rel[s]),
            .eff (req_eff)
        );

        irq_idx_resolve #(.IDX_W(IDX_W), .SID(s)) u_wait_idx (
            .idx (seq_wait_idx[3*s +: IDX_W]),
            .rel (seq_wait_rel[s]),
            .eff (wait_eff)
        );

        assign op        = irq_op_e'(seq_req_op[2*s +: 2]);
        assign start_sw  = seq_req_valid[s] && (op == OP_SETWAIT);
        assign wait_done = seq_wait_valid[s] && seq_wait_pol[s] && flags[wait_eff];

        // Decode this sequencer's set and clear contributions.
        always_comb begin
            set_per[s] = '0;
            clr_per[s] = '0;
            if (seq_req_valid[s] && (op == OP_SET || op == OP_SETWAIT))
                set_per[s] = NUM_FLAGS'(1) << req_eff;
            if (seq_req_valid[s] && op == OP_CLR)
                clr_per[s] = NUM_FLAGS'(1) << req_eff;
            if (wait_done)
                clr_per[s] = clr_per[s] | (NUM_FLAGS'(1) << wait_eff);
        end

        assign seq_wait_stall[s] = seq_wait_valid[s] && (flags[wait_eff] != seq_wait_pol[s]);

        irq_setwait_track #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start_sw),
            .start_idx (req_eff),
            .flags     (flags),
            .stall     (seq_stall[s])
        );
    end

    // Merge the per-sequencer vectors.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int s = 0; s < NUM_SEQ; s++) begin
            set_vec = set_vec | set_per[s];
            clr_vec = clr_vec | clr_per[s];
        end
    end

    irq_flag_bank #(.NUM_FLAGS(NUM_FLAGS), .VIS_FLAGS(VIS_FLAGS)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_vec      (set_vec),
        .clr_vec      (clr_vec),
        .cpu_clr_we   (cpu_clr_we),
        .cpu_clr_mask (cpu_clr_mask),
        .cpu_en_we    (cpu_en_we),
        .cpu_en_wdata (cpu_en_wdata),
        .flags        (flags),
        .irq          (cpu_irq)
    );

    assign cpu_flags = flags[VIS_FLAGS-1:0];
endmodule

// File: rtl/irq_flag_chk.sv
// Module: assertion checker for the IRQ flag unit, attached by bind.
// Assumes: single-cycle request pulses and no new request during a stall.
module irq_flag_chk
    import irq_pkg::*;
#(
    parameter int NUM_SEQ   = 4,
    parameter int VIS_FLAGS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SEQ-1:0]   seq_req_valid,
    input logic [2*NUM_SEQ-1:0] seq_req_op,
    input logic [3*NUM_SEQ-1:0] seq_req_idx,
    input logic [NUM_SEQ-1:0]   seq_req_rel,
    input logic [NUM_SEQ-1:0]   seq_stall,
    input logic [NUM_SEQ-1:0]   seq_wait_valid,
    input logic                 cpu_clr_we,
    input logic [VIS_FLAGS-1:0] cpu_clr_mask,
    input logic [VIS_FLAGS-1:0] cpu_flags,
    input logic                 cpu_irq
);
    // R2: a lone set from sequencer 0 on a visible flag shows up at the next edge
    p_lone_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req_valid == NUM_SEQ'(1) && seq_req_op[1:0] == OP_SET && !seq_req_rel[0]
         && !seq_req_idx[2] && seq_wait_valid == '0 && !cpu_clr_we)
        |=> cpu_flags[$past(seq_req_idx[1:0])]);

    // R9: a full-mask processor clear with no sequencer activity empties the visible flags
    p_cpu_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clr_we && cpu_clr_mask == '1 && seq_req_valid == '0)
        |=> cpu_flags == '0);

    // R11: the interrupt needs at least one visible flag
    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (cpu_flags != '0));

    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_chk
        // R8: a stall only starts after a set-and-wait request
        p_stall_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(seq_stall[s]) |->
            $past(seq_req_valid[s] && seq_req_op[2*s +: 2] == OP_SETWAIT));
    end
endmodule

bind irq_flag_unit irq_flag_chk #(.NUM_SEQ(NUM_SEQ), .VIS_FLAGS(VIS_FLAGS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .seq_req_valid  (seq_req_valid),
    .seq_req_op     (seq_req_op),
    .seq_req_idx    (seq_req_idx),
    .seq_req_rel    (seq_req_rel),
    .seq_stall      (seq_stall),
    .seq_wait_valid (seq_wait_valid),
    .cpu_clr_we     (cpu_clr_we),
    .cpu_clr_mask   (cpu_clr_mask),
    .cpu_flags      (cpu_flags),
    .cpu_irq        (cpu_irq)
);

// File: tb/sim_irq_flag_unit.sv
// Bench: directed scenarios for the IRQ flag unit, one task each.
module sim_irq_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  seq_req_valid;
    logic [7:0]  seq_req_op;
    logic [11:0] seq_req_idx;
    logic [3:0]  seq_req_rel;
    logic [3:0]  seq_stall;
    logic [3:0]  seq_wait_valid;
    logic [3:0]  seq_wait_pol;
    logic [11:0] seq_wait_idx;
    logic [3:0]  seq_wait_rel;
    logic [3:0]  seq_wait_stall;
    logic        cpu_clr_we;
    logic [3:0]  cpu_clr_mask;
    logic        cpu_en_we;
    logic [3:0]  cpu_en_wdata;
    logic [3:0]  cpu_flags;
    logic        cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    irq_flag_unit u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        seq_req_valid = '0; seq_req_op = '0; seq_req_idx = '0; seq_req_rel = '0;
        seq_wait_valid = '0; seq_wait_pol = '0; seq_wait_idx = '0; seq_wait_rel = '0;
        cpu_clr_we = 0; cpu_clr_mask = '0; cpu_en_we = 0; cpu_en_wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic req(input int s, input logic [1:0] op, input logic [2:0] idx, input logic rel);
        seq_req_valid[s]     = 1'b1;
        seq_req_op[2*s +: 2] = op;
        seq_req_idx[3*s +: 3] = idx;
        seq_req_rel[s]       = rel;
    endtask

    task automatic poll(input int s, input logic pol, input logic [2:0] idx, input logic rel);
        seq_wait_valid[s]      = 1'b1;
        seq_wait_pol[s]        = pol;
        seq_wait_idx[3*s +: 3] = idx;
        seq_wait_rel[s]        = rel;
    endtask

    task automatic cpu_clear(input logic [3:0] m);
        cpu_clr_we = 1; cpu_clr_mask = m; tick(); idle();
    endtask

    task automatic t_reset();
        chk("R1 flags", cpu_flags, 0);
        chk("R1 irq", cpu_irq, 0);
        chk("R1 stall", seq_stall, 0);
    endtask

    task automatic t_set_clear();
        req(0, 2'b00, 3'd1, 0); tick(); idle();
        chk("R2 set flag1", cpu_flags, 4'b0010);
        req(0, 2'b11, 3'd2, 0); tick(); idle();
        chk("R2 reserved op", cpu_flags, 4'b0010);
        req(1, 2'b01, 3'd1, 0); tick(); idle();
        chk("R3 clear flag1", cpu_flags, 4'b0000);
    endtask

    task automatic t_relative();
        req(3, 2'b00, 3'd2, 1); tick(); idle();
        chk("R4 seq3 rel2 -> flag1", cpu_flags, 4'b0010);
        cpu_clear(4'b1111);
        req(2, 2'b00, 3'd6, 1); tick(); idle();
        chk("R4 R10 private flag hidden", cpu_flags, 4'b0000);
        poll(0, 1, 3'd4, 0); #1;
        chk("R4 R6 flag4 high, poll passes", seq_wait_stall[0], 0);
        tick(); idle();
        poll(0, 1, 3'd4, 0); #1;
        chk("R7 flag4 consumed, poll stalls", seq_wait_stall[0], 1);
        seq_wait_pol[0] = 0; #1;
        chk("R6 low poll passes", seq_wait_stall[0], 0);
        idle();
    endtask

    task automatic t_priority();
        req(0, 2'b00, 3'd3, 0); req(1, 2'b01, 3'd3, 0); tick(); idle();
        chk("R5 seq clear beats set", cpu_flags, 4'b0000);
        req(0, 2'b00, 3'd0, 0); cpu_clr_we = 1; cpu_clr_mask = 4'b0001; tick(); idle();
        chk("R5 cpu clear beats set", cpu_flags, 4'b0000);
    endtask

    task automatic t_cpu();
        req(0, 2'b00, 3'd0, 0); req(1, 2'b00, 3'd1, 0); req(2, 2'b00, 3'd2, 0); tick(); idle();
        chk("R9 three flags set", cpu_flags, 4'b0111);
        cpu_clear(4'b0101);
        chk("R9 w1c partial", cpu_flags, 4'b0010);
        cpu_en_we = 1; cpu_en_wdata = 4'b0001; tick(); idle();
        chk("R11 masked irq", cpu_irq, 0);
        cpu_en_we = 1; cpu_en_wdata = 4'b0010; tick(); idle();
        chk("R11 enabled irq", cpu_irq, 1);
        cpu_en_we = 1; cpu_en_wdata = 4'b1111; cpu_clr_we = 1; cpu_clr_mask = 4'b1111;
        req(0, 2'b00, 3'd5, 0); tick(); idle();
        chk("R10 private flag no irq", cpu_irq, 0);
        cpu_clear(4'b1111);
    endtask

    task automatic t_setwait();
        req(0, 2'b10, 3'd2, 0); tick(); idle();
        chk("R8 flag set", cpu_flags, 4'b0100);
        chk("R8 stall starts", seq_stall[0], 1);
        tick(); tick();
        chk("R8 stall holds", seq_stall[0], 1);
        req(1, 2'b01, 3'd2, 0); tick(); idle();
        chk("R8 flag cleared", cpu_flags, 4'b0000);
        chk("R8 stall one more cycle", seq_stall[0], 1);
        tick();
        chk("R8 stall released", seq_stall[0], 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_set_clear();
        t_relative();
        t_priority();
        t_cpu();
        t_setwait();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule